// File: doc/BRIEF.md
# Asynchronous External Memory Controller

The controller links a simple internal request port to slow external memories such as SRAM, NOR flash or NAND-style parts. It drives four chip selects, and each one covers a 64 MB window. Address bits [27:26] of a host request pick the chip select. The lower 26 bits form the offset inside that window.

Every chip select has its own 32-bit timing word, held in a small register file that software writes and reads back. An access runs through three phases in order: setup, strobe and hold. Reads take their phase lengths from the read fields of the word and writes take them from the write fields. After the hold phase a turnaround gap passes before the controller takes the next request.

The timing word also controls three options. An extended-wait bit lets the external wait pin stretch the strobe phase. A select-strobe bit limits the chip enable to the strobe phase. A width bit picks an 8-bit or a 16-bit device.

Top module: `asyncmem_ctrl`

## Requirements
- R1: After reset, every timing word reads back 0x3FFF_FFFC, which means all timing fields are at their maximum, 8-bit width, and extended wait and select strobe are off. After reset all chip enables, output enable and write enable are high, the data bus is not driven, and the host port is ready.
- R2: A write to word `cfg_idx` stores `cfg_wdata` in that word only. Bit 1 is unused and always reads 0. The word layout is: bit 0 width (1 = 16-bit); [3:2] turnaround; [6:4] read hold; [12:7] read strobe; [16:13] read setup; [19:17] write hold; [25:20] write strobe; [29:26] write setup; bit 30 extended wait; bit 31 select strobe.
- R3: During an access only the chip enable chosen by `host_addr[27:26]` goes low. The other three stay high.
- R4: A read holds its chip enable low for (rsetup+1)+(rstrobe+1)+(rhold+1) cycles, when select strobe is off and no wait stretch occurs. Output enable is low for exactly the strobe cycles, and write enable stays high.
- R5: A write works the same way with the write setup, strobe and hold fields. Write enable is low for the strobe cycles, and output enable stays high.
- R6: After the hold phase, the port stays not-ready for a further turnaround+1 cycles. The port is busy for the three phases plus that gap, and then accepts the next request.
- R7: When extended wait is on, each strobe cycle that ends with `mem_wait` high does not count toward the strobe length, so the strobe phase grows by one cycle for each such cycle. When extended wait is off, `mem_wait` does not change the timing at all.
- R8: With select strobe on, the chip enable is low only during strobe cycles. Without it, the chip enable also covers the setup and hold cycles.
- R9: The data bus enable is high for every setup, strobe and hold cycle of a write, and never high during a read.
- R10: In 16-bit mode, `mem_addr` carries offset bits [25:1] and all 16 data bits are used. In 8-bit mode, `mem_addr` carries offset bits [25:0], write data drives only the low byte (the upper byte is driven zero), and read data returns zero in the upper byte.
- R11: A read takes `mem_dq_in` on the last strobe cycle and returns it on `host_rdata`, with `host_rvalid` high for exactly one cycle. Writes give no `host_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the timing word file |
| cfg_idx | input | 2 | Timing word index (chip select number), used for both writes and reads |
| cfg_wdata | input | 32 | Timing word write data |
| cfg_rdata | output | 32 | Timing word selected by cfg_idx |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Controller idle and able to accept a request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 28 | Byte address; bits [27:26] select the chip |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data |
| host_rvalid | output | 1 | One-cycle pulse when host_rdata holds new read data |
| mem_ce_n | output | 4 | Active-low chip enables |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_addr | output | 26 | External address |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data bus drivers |
| mem_dq_in | input | 16 | Data returned by the memory |
| mem_wait | input | 1 | External wait request |

## Verification
The hardest case to reach is a strobe phase stretched by the wait pin. Wait only has an effect when it overlaps the strobe and the extended-wait bit of the selected word is set, so it cannot be driven blindly. The bench therefore watches the strobe pins itself and raises `mem_wait` on the first strobe cycle it sees, for a chosen number of cycles. It does this with extended wait both on and off. Directed cases cover all-zero timing fields (one-cycle phases), full-scale fields and both width modes. Randomly filled timing words then mix these conditions across all four chip selects.

// File: rtl/amc_pkg.sv
// Shared types for the asynchronous memory controller.
// Assumes a 32-bit timing word per chip select, laid out MSB first as the struct below.
package amc_pkg;

    localparam int CFG_W = 32;
    localparam int CNT_W = 6;   // wide enough for the largest field (strobe, 63)

    typedef struct packed {
        logic       sel_strobe;  // [31]
        logic       ext_wait;    // [30]
        logic [3:0] wr_setup;    // [29:26]
        logic [5:0] wr_strobe;   // [25:20]
        logic [2:0] wr_hold;     // [19:17]
        logic [3:0] rd_setup;    // [16:13]
        logic [5:0] rd_strobe;   // [12:7]
        logic [2:0] rd_hold;     // [6:4]
        logic [1:0] turn;        // [3:2]
        logic       unused;      // [1]
        logic       wide;        // [0]
    } amc_cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_TURN   = 3'd4
    } amc_phase_t;

    // Reset word: all timing fields at their maximum, narrow width, options off.
    localparam amc_cfg_t CFG_RESET = '{
        sel_strobe: 1'b0, ext_wait: 1'b0,
        wr_setup: 4'hF, wr_strobe: 6'h3F, wr_hold: 3'h7,
        rd_setup: 4'hF, rd_strobe: 6'h3F, rd_hold: 3'h7,
        turn: 2'h3, unused: 1'b0, wide: 1'b0
    };

endpackage

// File: rtl/amc_cfg_regs.sv
// Timing word file: one word per chip select, written and read through one index.
// Assumes cfg_idx stays below NUM_CS; the unused bit is forced to zero on write.
module amc_cfg_regs
    import amc_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W = $clog2(NUM_CS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [CS_W-1:0]        idx,
    input  logic [CFG_W-1:0]       wdata,
    output logic [CFG_W-1:0]       rdata,
    output amc_cfg_t [NUM_CS-1:0]  cfg_all
);

    localparam logic [CFG_W-1:0] WR_MASK = ~(CFG_W'(1) << 1);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_word
        // Holds the timing word of chip select g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_all[g] <= CFG_RESET;
            else if (wr_en && idx == CS_W'(g))
                cfg_all[g] <= amc_cfg_t'(wdata & WR_MASK);
        end
    end

    // Read mux for the selected word.
    assign rdata = cfg_all[idx];

    p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[1] == 1'b0);

endmodule

// File: rtl/amc_seq.sv
// Access sequencer: accepts one host request at a time and steps through
// setup, strobe, hold and turnaround with one down counter.
// Assumes the timing word is captured when a request is accepted.
module amc_seq
    import amc_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 28,
    parameter int DATA_W = 16,
    localparam int CS_W  = $clog2(NUM_CS),
    localparam int WIN_W = ADDR_W - CS_W,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  amc_cfg_t [NUM_CS-1:0]  cfg_all,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   req_ready,
    input  logic                   mem_wait,
    input  logic [DATA_W-1:0]      mem_dq_in,
    output amc_phase_t             phase,
    output amc_cfg_t               cur_cfg,
    output logic                   cur_write,
    output logic [CS_W-1:0]        cur_cs,
    output logic [WIN_W-1:0]       cur_addr,
    output logic [DATA_W-1:0]      cur_wdata,
    output logic [DATA_W-1:0]      rdata,
    output logic                   rvalid
);

    logic [CNT_W-1:0] cnt;
    logic [CS_W-1:0]  req_cs;
    amc_cfg_t         req_cfg;
    logic             stall;
    logic             last;

    assign req_cs    = req_addr[ADDR_W-1 -: CS_W];
    assign req_cfg   = cfg_all[req_cs];
    assign req_ready = (phase == PH_IDLE);
    assign stall     = cur_cfg.ext_wait && mem_wait;
    assign last      = (cnt == '0);

    // Phase machine, phase counter and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            cur_cfg   <= CFG_RESET;
            cur_write <= 1'b0;
            cur_cs    <= '0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            rdata     <= '0;
            rvalid    <= 1'b0;
        end else begin
            rvalid <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        phase     <= PH_SETUP;
                        cnt       <= req_write ? CNT_W'(req_cfg.wr_setup)
                                               : CNT_W'(req_cfg.rd_setup);
                        cur_cfg   <= req_cfg;
                        cur_write <= req_write;
                        cur_cs    <= req_cs;
                        cur_addr  <= req_addr[WIN_W-1:0];
                        cur_wdata <= req_wdata;
                    end
                end
                PH_SETUP: begin
                    if (last) begin
                        phase <= PH_STROBE;
                        cnt   <= cur_write ? CNT_W'(cur_cfg.wr_strobe)
                                           : CNT_W'(cur_cfg.rd_strobe);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (stall) begin
                        cnt <= cnt;
                    end else if (last) begin
                        phase <= PH_HOLD;
                        cnt   <= cur_write ? CNT_W'(cur_cfg.wr_hold)
                                           : CNT_W'(cur_cfg.rd_hold);
                        if (!cur_write) begin
                            rdata  <= cur_cfg.wide ? mem_dq_in
                                    : {{HALF_W{1'b0}}, mem_dq_in[HALF_W-1:0]};
                            rvalid <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (last) begin
                        phase <= PH_TURN;
                        cnt   <= CNT_W'(cur_cfg.turn);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_TURN: begin
                    if (last) phase <= PH_IDLE;
                    else      cnt   <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    p_accept_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (phase == PH_SETUP));

    p_wait_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STROBE && stall) |=> (phase == PH_STROBE && cnt == $past(cnt)));

    p_rvalid_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (phase == PH_HOLD && !cur_write));

    p_turn_before_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD) |=> (phase == PH_HOLD || phase == PH_TURN));

endmodule

// File: rtl/amc_pins.sv
// Pin decoder: turns the sequencer phase and captured request into the
// external strobes, address and data bus drive.
// Assumes outputs decode straight from registered state (one gate level).
module amc_pins
    import amc_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int WIN_W  = 26,
    parameter int DATA_W = 16,
    localparam int CS_W  = $clog2(NUM_CS),
    localparam int HALF_W = DATA_W / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  amc_phase_t         phase,
    input  amc_cfg_t           cur_cfg,
    input  logic               cur_write,
    input  logic [CS_W-1:0]    cur_cs,
    input  logic [WIN_W-1:0]   cur_addr,
    input  logic [DATA_W-1:0]  cur_wdata,
    output logic [NUM_CS-1:0]  mem_ce_n,
    output logic               mem_oe_n,
    output logic               mem_we_n,
    output logic [WIN_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]  mem_dq_out,
    output logic               mem_dq_oe
);

    logic in_access;
    logic in_strobe;
    logic ce_on;

    assign in_access = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    assign in_strobe = (phase == PH_STROBE);
    assign ce_on     = cur_cfg.sel_strobe ? in_strobe : in_access;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_ce
        // Chip enable g is low only while its chip select owns the access.
        assign mem_ce_n[g] = !(ce_on && cur_cs == CS_W'(g));
    end

    // Strobes, bus enable, and width-dependent address and data shaping.
    always_comb begin
        mem_oe_n   = !(in_strobe && !cur_write);
        mem_we_n   = !(in_strobe && cur_write);
        mem_dq_oe  = in_access && cur_write;
        mem_addr   = cur_cfg.wide ? {1'b0, cur_addr[WIN_W-1:1]} : cur_addr;
        mem_dq_out = cur_cfg.wide ? cur_wdata
                   : {{HALF_W{1'b0}}, cur_wdata[HALF_W-1:0]};
    end

    p_single_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_ce_n) <= 1);

    p_oe_we_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    p_no_drive_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    p_ss_ce_in_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_cfg.sel_strobe && mem_ce_n != '1) |-> (!mem_oe_n || !mem_we_n));

endmodule

// File: rtl/asyncmem_ctrl.sv
// Top of the asynchronous external memory controller: timing word file,
// access sequencer and pin decoder.
// Assumes one outstanding host request; host_ready low means busy.
module asyncmem_ctrl
    import amc_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 28,
    parameter int DATA_W = 16,
    localparam int CS_W  = $clog2(NUM_CS),
    localparam int WIN_W = ADDR_W - CS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CS_W-1:0]    cfg_idx,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    input  logic               host_valid,
    output logic               host_ready,
    input  logic               host_write,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               host_rvalid,
    output logic [NUM_CS-1:0]  mem_ce_n,
    output logic               mem_oe_n,
    output logic               mem_we_n,
    output logic [WIN_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]  mem_dq_out,
    output logic               mem_dq_oe,
    input  logic [DATA_W-1:0]  mem_dq_in,
    input  logic               mem_wait
);

    amc_cfg_t [NUM_CS-1:0] cfg_all;
    amc_phase_t            phase;
    amc_cfg_t              cur_cfg;
    logic                  cur_write;
    logic [CS_W-1:0]       cur_cs;
    logic [WIN_W-1:0]      cur_addr;
    logic [DATA_W-1:0]     cur_wdata;

    amc_cfg_regs #(.NUM_CS(NUM_CS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .idx     (cfg_idx),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .cfg_all (cfg_all)
    );

    amc_seq #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_all   (cfg_all),
        .req_valid (host_valid),
        .req_write (host_write),
        .req_addr  (host_addr),
        .req_wdata (host_wdata),
        .req_ready (host_ready),
        .mem_wait  (mem_wait),
        .mem_dq_in (mem_dq_in),
        .phase     (phase),
        .cur_cfg   (cur_cfg),
        .cur_write (cur_write),
        .cur_cs    (cur_cs),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .rdata     (host_rdata),
        .rvalid    (host_rvalid)
    );

    amc_pins #(.NUM_CS(NUM_CS), .WIN_W(WIN_W), .DATA_W(DATA_W)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .cur_cfg    (cur_cfg),
        .cur_write  (cur_write),
        .cur_cs     (cur_cs),
        .cur_addr   (cur_addr),
        .cur_wdata  (cur_wdata),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe)
    );

endmodule

// File: tb/sim_asyncmem_ctrl.sv
// Bench: directed corners plus seeded random accesses, timing measured at the pins.
module sim_asyncmem_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        host_valid = 1'b0;
    logic        host_ready;
    logic        host_write = 1'b0;
    logic [27:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic [3:0]  mem_ce_n;
    logic        mem_oe_n, mem_we_n, mem_dq_oe;
    logic [25:0] mem_addr;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in;
    logic        mem_wait = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] shadow [4];

    always #2 clk = ~clk;   // 250 MHz

    // Memory model: read data is a fixed function of the address pins.
    assign mem_dq_in = mem_addr[15:0] ^ 16'hA5C3;

    asyncmem_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_wait(mem_wait)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(input int idx, input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        shadow[idx] = w & 32'hFFFF_FFFD;
    endtask

    task automatic cfg_check(input int idx, input string tag);
        @(negedge clk);
        cfg_idx = 2'(idx);
        #1;
        chk(tag, cfg_rdata, shadow[idx]);
    endtask

    // One access; counts pin activity per cycle and compares with the timing word.
    task automatic access(input bit wr, input logic [27:0] addr,
                          input logic [15:0] wd, input int wait_n);
        int cs, busy, n_ce, n_ce_off, n_oe, n_we, n_dq, n_bad, n_rv, wleft, guard;
        bit seen, strobe;
        logic [31:0] w;
        logic [25:0] cap_addr, exp_addr;
        logic [15:0] cap_dq, rd, exp_dq, exp_rd;
        int su, st, ho, ta, stb, phases;
        cs = int'(addr[27:26]);
        w  = shadow[cs];
        busy = 0; n_ce = 0; n_ce_off = 0; n_oe = 0; n_we = 0; n_dq = 0;
        n_bad = 0; n_rv = 0; seen = 0; wleft = wait_n; guard = 0;
        cap_addr = '0; cap_dq = '0; rd = '0;
        @(negedge clk);
        chk("R6 ready before request", 32'(host_ready), 32'd1);
        host_valid = 1'b1; host_write = wr; host_addr = addr; host_wdata = wd;
        @(negedge clk);
        host_valid = 1'b0;
        while (!host_ready && guard < 2000) begin
            guard++;
            busy++;
            for (int i = 0; i < 4; i++)
                if (i != cs && !mem_ce_n[i]) n_bad++;
            strobe = !mem_oe_n || !mem_we_n;
            if (!mem_ce_n[cs]) n_ce++;
            if (!mem_ce_n[cs] && !strobe) n_ce_off++;
            if (!mem_oe_n) n_oe++;
            if (!mem_we_n) n_we++;
            if (mem_dq_oe) n_dq++;
            if (strobe && !seen) begin
                seen = 1; cap_addr = mem_addr; cap_dq = mem_dq_out;
            end
            if (host_rvalid) begin n_rv++; rd = host_rdata; end
            if (strobe && wleft > 0) begin mem_wait = 1'b1; wleft--; end
            else mem_wait = 1'b0;
            @(negedge clk);
        end
        mem_wait = 1'b0;
        su = wr ? int'(w[29:26]) : int'(w[16:13]);
        st = wr ? int'(w[25:20]) : int'(w[12:7]);
        ho = wr ? int'(w[19:17]) : int'(w[6:4]);
        ta = int'(w[3:2]);
        stb = st + 1 + (w[30] ? wait_n : 0);
        phases = su + 1 + stb + ho + 1;
        exp_addr = w[0] ? {1'b0, addr[25:1]} : addr[25:0];
        exp_dq   = w[0] ? wd : {8'h00, wd[7:0]};
        exp_rd   = w[0] ? (exp_addr[15:0] ^ 16'hA5C3)
                        : {8'h00, exp_addr[7:0] ^ 8'hC3};
        chk("R6 busy cycles", 32'(busy), 32'(phases + ta + 1));
        chk("R3 other chip enables", 32'(n_bad), 32'd0);
        chk("R8 ce low cycles", 32'(n_ce), 32'(w[31] ? stb : phases));
        chk("R8 ce outside strobe", 32'(n_ce_off), 32'(w[31] ? 0 : su + ho + 2));
        if (wr) begin
            chk("R5 we strobe cycles", 32'(n_we), 32'(stb));
            chk("R5 oe quiet on write", 32'(n_oe), 32'd0);
            chk("R9 bus drive cycles", 32'(n_dq), 32'(phases));
            chk("R10 write data", 32'(cap_dq), 32'(exp_dq));
            chk("R11 no rvalid on write", 32'(n_rv), 32'd0);
        end else begin
            chk("R4 oe strobe cycles", 32'(n_oe), 32'(stb));
            chk("R4 we quiet on read", 32'(n_we), 32'd0);
            chk("R9 no drive on read", 32'(n_dq), 32'd0);
            chk("R11 one rvalid", 32'(n_rv), 32'd1);
            chk("R11 read data", 32'(rd), 32'(exp_rd));
        end
        chk("R7 strobe with wait", 32'(wr ? n_we : n_oe), 32'(stb));
        chk("R10 address", 32'(cap_addr), 32'(exp_addr));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned seedval;
        logic [31:0] w;
        seedval = $urandom(32'd715);
        for (int i = 0; i < 4; i++) shadow[i] = 32'h3FFF_FFFC;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of words and pins
        for (int i = 0; i < 4; i++) cfg_check(i, "R1 reset word");
        chk("R1 ce idle", 32'(mem_ce_n), 32'hF);
        chk("R1 oe/we idle", 32'({mem_oe_n, mem_we_n}), 32'h3);
        chk("R1 bus idle", 32'(mem_dq_oe), 32'd0);
        chk("R1 ready", 32'(host_ready), 32'd1);
        // R4 R5 with reset (maximum) timing, 8-bit width
        access(1'b0, 28'h0000123, 16'h0, 0);
        access(1'b1, 28'h4000456, 16'hBEEF, 0);
        // R2: write with unused bit set, only the addressed word changes
        cfg_write(2, 32'hFFFF_FFFF);
        cfg_check(2, "R2 readback unused bit clear");
        cfg_check(1, "R2 neighbour unchanged");
        // All-zero timing, 16-bit: one-cycle phases
        cfg_write(0, 32'h0000_0001);
        cfg_check(0, "R2 readback zero timing");
        access(1'b0, 28'h0001235, 16'h0, 0);
        access(1'b1, 28'h0003FFE, 16'h1234, 0);
        // R8 select strobe, R7 extended wait on and off
        cfg_write(1, 32'h8000_0000 | (32'd3 << 26) | (32'd4 << 20) | (32'd2 << 17)
                   | (32'd2 << 13) | (32'd5 << 7) | (32'd1 << 4) | (32'd2 << 2) | 32'd1);
        access(1'b0, 28'h4000010, 16'h0, 0);
        access(1'b1, 28'h4000011, 16'hCAFE, 0);
        cfg_write(3, 32'h4000_0000 | (32'd1 << 26) | (32'd2 << 20) | (32'd3 << 7)
                   | (32'd1 << 13) | (32'd1 << 2));
        access(1'b0, 28'hC0000AB, 16'h0, 4);
        access(1'b1, 28'hC0000CD, 16'h77AA, 3);
        cfg_write(3, 32'h0000_0000 | (32'd2 << 20) | (32'd3 << 7));
        access(1'b0, 28'hC0000EF, 16'h0, 5);
        // Random timing words and accesses
        for (int k = 0; k < 40; k++) begin
            if (k % 4 == 0)
                for (int i = 0; i < 4; i++) begin
                    w = $urandom;
                    cfg_write(i, w);
                    cfg_check(i, "R2 random readback");
                end
            access(1'($urandom), 28'($urandom), 16'($urandom), int'($urandom % 6));
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule